// File: doc/BRIEF.md
# Multi-Cycle Unsigned Integer Divider with Configurable Radix

This block divides one unsigned integer by another over several clock cycles and returns both the quotient and the remainder. A caller places the two operands on the inputs and raises `start` for one cycle while the block is idle. The block then works from the most significant quotient position down to the least significant. In each cycle it produces a group of quotient bits, and it raises `done` for one cycle when the last group is in place. The results stay on the outputs until the next accepted request.

Two parameters set the operand width and the number of quotient bits retired per cycle, which is the base-two logarithm of the radix. In every cycle all candidate digits of the radix are tried at the same time. Each candidate multiple of the divisor, shifted to the current position, is subtracted from the running remainder using one extra sign bit. The largest candidate that leaves a non-negative result is kept. When the width is not a multiple of the group size, the final cycle retires only the bits that are left.

A zero divisor needs no special path. Every trial then succeeds, so the quotient fills with ones and the remainder keeps the dividend.

Top module: `radix_divider`

## Requirements
- R1: After reset, `busy` and `done` are low and `quotient` and `remainder` are zero.
- R2: For a nonzero divisor, the final `quotient` equals the dividend divided by the divisor rounded down, and `remainder` equals the dividend modulo the divisor. Both are treated as unsigned WIDTH-bit values.
- R3: For a zero divisor, the final `quotient` has all WIDTH bits set to one and `remainder` equals the dividend.
- R4: `done` rises exactly ceil(WIDTH / LOG2_RADIX) clock edges after the edge that accepts `start`, and it stays high for exactly one cycle.
- R5: Each cycle retires the smaller of LOG2_RADIX and the number of quotient bits still open. With WIDTH=6 and LOG2_RADIX=4, the operation therefore ends after 2 cycles, the second of which retires 2 bits.
- R6: A `start` that arrives while `busy` is high is ignored. The operands of the running operation and its result are unaffected.
- R7: While idle and with `start` low, `quotient` and `remainder` hold their values.
- R8: Throughout an operation, and at its end, the latched dividend equals quotient × divisor + partial remainder.
- R9: `busy` is high from the accepting edge until the edge that raises `done`, and it is low from that edge onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | WIDTH | Unsigned numerator, sampled on the accepting edge |
| divisor | input | WIDTH | Unsigned denominator, sampled on the accepting edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the results are final |
| quotient | output | WIDTH | Quotient; partial while busy, final from `done` on |
| remainder | output | WIDTH | Remainder; partial while busy, final from `done` on |

## Verification
The assertions assume that the operands are sampled only on the accepting edge. They also assume that the caller raises `start` only as a single-cycle request, although a request during an operation is allowed and must be dropped. The stimulus drives inputs on the falling edge and sweeps every pair of 6-bit operands, the zero divisor included. It runs one instance for each radix of 2, 4, 8 and 16, so both exact and shortened final steps occur. On a fixed subset of operand pairs, a second request with different operands is issued one cycle into the operation. This exercises the ignore path while the operands on the pins differ from those held inside.

// File: rtl/radix_divider.sv
module radix_divider #(
  parameter int WIDTH      = 8,
  parameter int LOG2_RADIX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int RADIX = 1 << LOG2_RADIX;
  localparam int CW    = $clog2(WIDTH + 1);
  localparam int TW    = 2 * WIDTH + LOG2_RADIX + 1;
  localparam int PW    = 2 * WIDTH;

  logic [CW-1:0]         shift_q;
  logic [CW-1:0]         step;
  logic [CW-1:0]         shift_nx;
  logic [WIDTH-1:0]      dvsr_q;
  logic [WIDTH-1:0]      dvnd_q;
  logic [TW-1:0]         rem_wide;
  logic [TW-1:0]         trial [RADIX];
  logic [RADIX-1:0]      ok;
  logic [LOG2_RADIX-1:0] digit;

  assign step     = (int'(shift_q) > LOG2_RADIX) ? CW'(LOG2_RADIX) : shift_q;
  assign shift_nx = shift_q - step;
  assign rem_wide = TW'(remainder);

  for (genvar i = 0; i < RADIX; i++) begin : g_cand
    logic [TW-1:0] sub;
    assign sub      = (TW'(dvsr_q) * TW'(i)) << shift_nx;
    assign trial[i] = rem_wide - sub;
    assign ok[i]    = !trial[i][TW-1] && ((i >> step) == 0);
  end

  always_comb begin
    digit = '0;
    for (int i = 0; i < RADIX; i++)
      if (ok[i]) digit = LOG2_RADIX'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      shift_q   <= '0;
      dvsr_q    <= '0;
      dvnd_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy      <= 1'b1;
        quotient  <= '0;
        remainder <= dividend;
        dvsr_q    <= divisor;
        dvnd_q    <= dividend;
        shift_q   <= CW'(WIDTH);
      end else if (busy) begin
        remainder <= trial[digit][WIDTH-1:0];
        quotient  <= quotient | (WIDTH'(digit) << shift_nx);
        shift_q   <= shift_nx;
        if (shift_nx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8
  identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> PW'(dvnd_q) == PW'(quotient) * PW'(dvsr_q) + PW'(remainder));
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvsr_q != '0) |-> remainder < dvsr_q);
  // R3
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvsr_q == '0) |-> (&quotient && remainder == dvnd_q));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  hold_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dvsr_q) && $stable(dvnd_q)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_radix_divider.sv
`timescale 1ns/1ps
module tb_radix_divider;
  localparam int W = 6;
  localparam int NV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [NV-1:0] bsy;
  logic [NV-1:0] dn;
  logic [NV-1:0][W-1:0] qo;
  logic [NV-1:0][W-1:0] ro;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  for (genvar k = 0; k < NV; k++) begin : g_r
    radix_divider #(.WIDTH(W), .LOG2_RADIX(k + 1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend(a_in), .divisor(b_in),
      .busy(bsy[k]), .done(dn[k]),
      .quotient(qo[k]), .remainder(ro[k]));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit restart);
    int eq;
    int er;
    eq = (b == 0) ? (1 << W) - 1 : a / b;
    er = (b == 0) ? a : a % b;
    @(negedge clk);
    start = 1'b1; a_in = W'(a); b_in = W'(b);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 7; c++) begin
      if (restart && c == 1) begin
        start = 1'b1; a_in = ~W'(a); b_in = W'(b + 1);
      end
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < NV; k++) begin
        int n;
        n = (W + k) / (k + 1);
        if (k == 3) chk(dn[k] == (c == n), "R5 short final step", int'(dn[k]), int'(c == n));
        else chk(dn[k] == (c == n), "R4 done timing", int'(dn[k]), int'(c == n));
        chk(bsy[k] == (c < n), "R9 busy window", int'(bsy[k]), int'(c < n));
        if (c == n) begin
          if (b == 0) begin
            chk(int'(qo[k]) == eq, "R3 zero divisor quotient", int'(qo[k]), eq);
            chk(int'(ro[k]) == er, "R3 zero divisor remainder", int'(ro[k]), er);
          end else begin
            chk(int'(qo[k]) == eq, restart ? "R6 quotient after ignored start" : "R2 quotient", int'(qo[k]), eq);
            chk(int'(ro[k]) == er, restart ? "R6 remainder after ignored start" : "R2 remainder", int'(ro[k]), er);
          end
          chk(int'(qo[k]) * b + int'(ro[k]) == a, "R8 identity", int'(qo[k]) * b + int'(ro[k]), a);
        end
      end
    end
    for (int k = 0; k < NV; k++) begin
      chk(!dn[k] && !bsy[k], "R4 single pulse", int'(dn[k]), 0);
      chk(int'(qo[k]) == eq, "R7 quotient held", int'(qo[k]), eq);
      chk(int'(ro[k]) == er, "R7 remainder held", int'(ro[k]), er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      chk(!bsy[k] && !dn[k], "R1 control idle", int'({bsy[k], dn[k]}), 0);
      chk(qo[k] == '0 && ro[k] == '0, "R1 outputs zero", int'(qo[k]) + int'(ro[k]), 0);
    end
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_op(a, b, ((a + b) % 5) == 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule